// File: doc/BRIEF.md
# Sequential Shift-Add Integer Multiplier

This block multiplies two operands of OPW bits (32 by default) over many clock cycles, using a single OPW-bit adder instead of a full array of partial-product adders. A 2·OPW-bit accumulation register carries both the running partial product and the not-yet-consumed multiplier bits. When a multiply is launched, the upper half of this register is zeroed and the lower half receives the multiplier. On each step, the register's lowest bit decides whether the stored multiplicand is added into the upper half. The adder's carry and sum, together with the remaining lower bits, then shift right by one place. After OPW steps the register holds the full product.

An operand-type input chooses between unsigned and two's-complement operation. In two's-complement operation, the block first converts both operands to magnitudes, multiplies those magnitudes as unsigned numbers, and negates the double-width result if exactly one operand was negative. The most negative operand value, whose magnitude only fits as an unsigned number, is handled correctly.

A one-cycle launch pulse is honoured only while the block is idle. A busy flag covers the iteration. A completion pulse lasting one cycle marks the product as valid, and the product then holds until the next launch.

Top module: `seqmul_core`

## Requirements
- R1: After reset, busy_o and done_o are 0 and prod_o is all zeros.
- R2: A high start_i is accepted only in a cycle where busy_o is 0. A start_i pulse while busy_o is 1 has no effect on the running product or on its timing.
- R3: After an accepted start, busy_o is 1 for exactly OPW cycles (32). done_o is then 1 for exactly one cycle, in the first cycle with busy_o back at 0, which is OPW+1 cycles after the accepting edge. busy_o and done_o are never 1 together.
- R4: With signed_i = 0, prod_o equals the full 2·OPW-bit unsigned product of mcand_i and mplier_i, including all-ones operands, whose product needs the carry out of every add.
- R5: With signed_i = 1, prod_o equals the 2·OPW-bit two's-complement product for every combination of operand signs.
- R6: With signed_i = 1, an operand equal to the most negative value (only bit OPW-1 set) gives the correct product. Its square is 2^(2·OPW-2).
- R7: From a done_o pulse until the next accepted start, prod_o does not change.
- R8: signed_i, mcand_i and mplier_i are sampled only at the accepting edge. Changing them while busy_o is 1 does not alter the result.
- R9: A zero operand gives a zero product in both modes, including a zero times the most negative value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch pulse, honoured only while busy_o is 0 |
| signed_i | input | 1 | 1 selects two's-complement operands, 0 selects unsigned operands |
| mcand_i | input | OPW | Multiplicand |
| mplier_i | input | OPW | Multiplier |
| busy_o | output | 1 | High while iterating |
| done_o | output | 1 | One-cycle pulse when prod_o becomes valid |
| prod_o | output | 2·OPW | Product, held after done_o until the next launch |

## Verification
Unsigned products use small values, alternating bit patterns and all-ones operands. The all-ones case separates a design that keeps the adder carry from one that drops it. Signed products cover all four sign pairings, and each pairing shows whether the final negation is driven by the exclusive-or of the operand signs. Operands at the most negative value, squared and crossed with one and with zero, distinguish a correct magnitude conversion from one that overflows. A launch pulse, together with new operands and a flipped mode bit issued halfway through a run, shows whether the block samples its inputs only when idle.

// File: rtl/seqmul_pkg.sv
package seqmul_pkg;
   typedef enum logic {
      SM_IDLE = 1'b0,
      SM_RUN  = 1'b1
   } seqmul_state_e;
endpackage

// File: rtl/seqmul_operand_prep.sv
// Turns the raw operands into magnitudes and records whether the result must be negated.
module seqmul_operand_prep #(
   parameter int OPW       = 32,
   parameter bit SIGNED_EN = 1'b1
) (
   input  logic [OPW-1:0] mcand_i,
   input  logic [OPW-1:0] mplier_i,
   input  logic           signed_i,
   output logic [OPW-1:0] mcand_mag_o,
   output logic [OPW-1:0] mplier_mag_o,
   output logic           negate_o
);
   generate
      if (SIGNED_EN) begin : g_signed
         logic neg_a, neg_b;
         always_comb begin
            neg_a = signed_i & mcand_i[OPW-1];
            neg_b = signed_i & mplier_i[OPW-1];
            // The most negative value maps to 2^(OPW-1), which still fits unsigned.
            mcand_mag_o  = neg_a ? (~mcand_i + 1'b1)  : mcand_i;
            mplier_mag_o = neg_b ? (~mplier_i + 1'b1) : mplier_i;
            negate_o     = neg_a ^ neg_b;
         end
      end else begin : g_unsigned
         logic unused_mode;
         always_comb begin
            unused_mode  = signed_i;
            mcand_mag_o  = mcand_i;
            mplier_mag_o = mplier_i;
            negate_o     = 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/seqmul_ctrl.sv
// Sequencer: accepts a launch when idle, counts OPW steps, and emits the completion pulse.
module seqmul_ctrl
   import seqmul_pkg::*;
#(
   parameter int OPW = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic load_o,
   output logic step_o,
   output logic busy_o,
   output logic done_o
);
   localparam int CW = (OPW > 2) ? $clog2(OPW) : 1;
   localparam logic [CW-1:0] LAST_STEP = CW'(OPW - 1);

   seqmul_state_e state_q;
   logic [CW-1:0] step_cnt_q;
   logic          done_q;
   logic          last_step;

   always_comb begin
      load_o    = start_i && (state_q == SM_IDLE);
      step_o    = (state_q == SM_RUN);
      last_step = step_o && (step_cnt_q == LAST_STEP);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= SM_IDLE;
         step_cnt_q <= '0;
         done_q     <= 1'b0;
      end else begin
         done_q <= last_step;
         if (load_o) begin
            state_q    <= SM_RUN;
            step_cnt_q <= '0;
         end else if (last_step) begin
            state_q    <= SM_IDLE;
            step_cnt_q <= '0;
         end else if (step_o) begin
            step_cnt_q <= step_cnt_q + 1'b1;
         end
      end
   end

   assign busy_o = (state_q == SM_RUN);
   assign done_o = done_q;
endmodule

// File: rtl/seqmul_datapath.sv
// Accumulation register: upper half is the partial product, lower half holds the unconsumed multiplier bits.
module seqmul_datapath #(
   parameter int OPW = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             step_i,
   input  logic [OPW-1:0]   mcand_mag_i,
   input  logic [OPW-1:0]   mplier_mag_i,
   input  logic             negate_i,
   output logic [2*OPW-1:0] acc_o,
   output logic             negate_o
);
   localparam int PW = 2 * OPW;

   logic [OPW-1:0] mcand_q;
   logic [PW-1:0]  acc_q;
   logic           negate_q;
   logic [OPW:0]   addend;
   logic [OPW:0]   sum;

   always_comb begin
      addend = acc_q[0] ? {1'b0, mcand_q} : '0;
      sum    = {1'b0, acc_q[PW-1:OPW]} + addend;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mcand_q  <= '0;
         acc_q    <= '0;
         negate_q <= 1'b0;
      end else if (load_i) begin
         mcand_q  <= mcand_mag_i;
         acc_q    <= {{OPW{1'b0}}, mplier_mag_i};
         negate_q <= negate_i;
      end else if (step_i) begin
         // The carry lands in the top bit as the whole register moves right.
         acc_q <= {sum, acc_q[OPW-1:1]};
      end
   end

   assign acc_o    = acc_q;
   assign negate_o = negate_q;
endmodule

// File: rtl/seqmul_result_fix.sv
// Applies the final two's-complement negation when the operand signs differed.
module seqmul_result_fix #(
   parameter int OPW       = 32,
   parameter bit SIGNED_EN = 1'b1
) (
   input  logic [2*OPW-1:0] acc_i,
   input  logic             negate_i,
   output logic [2*OPW-1:0] prod_o
);
   generate
      if (SIGNED_EN) begin : g_negate
         assign prod_o = negate_i ? (~acc_i + 1'b1) : acc_i;
      end else begin : g_pass
         logic unused_neg;
         assign unused_neg = negate_i;
         assign prod_o     = acc_i;
      end
   endgenerate
endmodule

// File: rtl/seqmul_core.sv
module seqmul_core #(
   parameter int OPW       = 32,
   parameter bit SIGNED_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             signed_i,
   input  logic [OPW-1:0]   mcand_i,
   input  logic [OPW-1:0]   mplier_i,
   output logic             busy_o,
   output logic             done_o,
   output logic [2*OPW-1:0] prod_o
);
   generate
      if (OPW < 2) begin : g_bad_width
         $error("seqmul_core: OPW must be at least 2");
      end
   endgenerate

   logic [OPW-1:0]   mcand_mag, mplier_mag;
   logic             negate_in, negate_q;
   logic             load, step;
   logic [2*OPW-1:0] acc;

   seqmul_operand_prep #(.OPW(OPW), .SIGNED_EN(SIGNED_EN)) u_prep (
      .mcand_i      (mcand_i),
      .mplier_i     (mplier_i),
      .signed_i     (signed_i),
      .mcand_mag_o  (mcand_mag),
      .mplier_mag_o (mplier_mag),
      .negate_o     (negate_in)
   );

   seqmul_ctrl #(.OPW(OPW)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .load_o  (load),
      .step_o  (step),
      .busy_o  (busy_o),
      .done_o  (done_o)
   );

   seqmul_datapath #(.OPW(OPW)) u_dp (
      .clk          (clk),
      .rst_n        (rst_n),
      .load_i       (load),
      .step_i       (step),
      .mcand_mag_i  (mcand_mag),
      .mplier_mag_i (mplier_mag),
      .negate_i     (negate_in),
      .acc_o        (acc),
      .negate_o     (negate_q)
   );

   seqmul_result_fix #(.OPW(OPW), .SIGNED_EN(SIGNED_EN)) u_fix (
      .acc_i    (acc),
      .negate_i (negate_q),
      .prod_o   (prod_o)
   );
endmodule

// File: rtl/seqmul_chk.sv
module seqmul_chk #(
   parameter int OPW = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic             busy_o,
   input logic             done_o,
   input logic [2*OPW-1:0] prod_o
);
   localparam int KW = $clog2(OPW + 1) + 1;
   logic [KW-1:0] run_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 run_len <= '0;
      else if (start_i && !busy_o) run_len <= '0;
      else if (busy_o)            run_len <= run_len + 1'b1;
   end

   // R2
   launch_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> busy_o);

   // R3
   busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy_o && done_o));

   // R3
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R3
   busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (run_len == KW'(OPW)));

   // R3
   busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> done_o);

   // R7
   prod_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> $stable(prod_o));
endmodule

bind seqmul_core seqmul_chk #(.OPW(OPW)) u_seqmul_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start_i (start_i),
   .busy_o  (busy_o),
   .done_o  (done_o),
   .prod_o  (prod_o)
);

// File: tb/seqmul_core_bench.sv
`timescale 1ns/1ps
module seqmul_core_bench;
   localparam int W = 32;
   localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};
   localparam logic [W-1:0] ONES = '1;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start_i = 1'b0;
   logic           signed_i = 1'b0;
   logic [W-1:0]   mcand_i = '0;
   logic [W-1:0]   mplier_i = '0;
   logic           busy_o, done_o;
   logic [2*W-1:0] prod_o;

   int total = 0;
   int bad = 0;

   always #4 clk = ~clk;

   seqmul_core u_seqmul_core (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .signed_i(signed_i),
      .mcand_i(mcand_i), .mplier_i(mplier_i),
      .busy_o(busy_o), .done_o(done_o), .prod_o(prod_o)
   );

   function automatic logic [2*W-1:0] ref_mul(logic [W-1:0] a, logic [W-1:0] b, logic s);
      logic [2*W-1:0] ea, eb;
      ea = s ? {{W{a[W-1]}}, a} : {{W{1'b0}}, a};
      eb = s ? {{W{b[W-1]}}, b} : {{W{1'b0}}, b};
      return ea * eb;
   endfunction

   task automatic check(string req, logic [2*W-1:0] act, logic [2*W-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Launches one multiply; optionally disturbs inputs mid-run. Checks latency and result.
   task automatic run_mul(string req, logic [W-1:0] a, logic [W-1:0] b, logic s, bit disturb);
      int cyc;
      logic [2*W-1:0] exp;
      exp = ref_mul(a, b, s);
      @(negedge clk);
      start_i = 1'b1; mcand_i = a; mplier_i = b; signed_i = s;
      cyc = 0;
      while (cyc < 100) begin
         @(negedge clk);
         cyc++;
         start_i = 1'b0;
         if (cyc == 1) check({req, " R3 busy after launch"}, 64'(busy_o), 64'd1);
         if (disturb && cyc == 5) begin
            // R2 R8: launch pulse and new inputs while busy must be ignored
            start_i = 1'b1; mcand_i = ~a; mplier_i = 32'h1234_5678; signed_i = ~s;
         end
         if (done_o) break;
      end
      start_i = 1'b0;
      check({req, " R3 latency"}, 64'(cyc), 64'(W + 1));
      check({req, " result"}, prod_o, exp);
      @(negedge clk);
      check({req, " R3 done one cycle"}, 64'(done_o), 64'd0);
   endtask

   task automatic t_reset();
      check("R1 busy", 64'(busy_o), 64'd0);
      check("R1 done", 64'(done_o), 64'd0);
      check("R1 prod", prod_o, '0);
   endtask

   task automatic t_unsigned();
      run_mul("R4 small", 32'd7, 32'd6, 1'b0, 1'b0);
      run_mul("R4 pattern", 32'hAAAA_5555, 32'h0F0F_F0F0, 1'b0, 1'b0);
      run_mul("R4 all ones", ONES, ONES, 1'b0, 1'b0);
      run_mul("R4 msb unsigned", MINV, 32'd3, 1'b0, 1'b0);
   endtask

   task automatic t_signed();
      run_mul("R5 pos pos", 32'd7, 32'd3, 1'b1, 1'b0);
      run_mul("R5 pos neg", 32'd7, -32'sd3, 1'b1, 1'b0);
      run_mul("R5 neg pos", -32'sd7, 32'd3, 1'b1, 1'b0);
      run_mul("R5 neg neg", -32'sd123457, -32'sd98765, 1'b1, 1'b0);
   endtask

   task automatic t_most_negative();
      run_mul("R6 min squared", MINV, MINV, 1'b1, 1'b0);
      check("R6 min squared value", prod_o, 64'h4000_0000_0000_0000);
      run_mul("R6 min times one", MINV, 32'd1, 1'b1, 1'b0);
      run_mul("R6 min times minus one", MINV, ONES, 1'b1, 1'b0);
   endtask

   task automatic t_zero();
      run_mul("R9 zero unsigned", 32'd0, ONES, 1'b0, 1'b0);
      check("R9 zero unsigned value", prod_o, '0);
      run_mul("R9 zero times min", MINV, 32'd0, 1'b1, 1'b0);
      check("R9 zero signed value", prod_o, '0);
   endtask

   task automatic t_hold();
      logic [2*W-1:0] held;
      run_mul("R7 base", 32'hDEAD_BEEF, 32'd77, 1'b0, 1'b0);
      held = prod_o;
      mcand_i = 32'd1; mplier_i = 32'd1; signed_i = 1'b1;
      repeat (6) @(negedge clk);
      check("R7 prod held while idle", prod_o, held);
      check("R7 no spurious done", 64'(done_o), 64'd0);
   endtask

   task automatic t_ignore_busy_start();
      run_mul("R2 R8 disturbed unsigned", 32'hFFFF_0001, 32'h8000_0003, 1'b0, 1'b1);
      run_mul("R2 R8 disturbed signed", -32'sd55, 32'd1000, 1'b1, 1'b1);
   endtask

   initial begin
      #(200000 * 8);
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_unsigned();
      t_signed();
      t_most_negative();
      t_zero();
      t_hold();
      t_ignore_busy_start();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule